// File: doc/BRIEF.md
# Dual-Convention Microprocessor Register Interface

This block is a register-access slave. It connects a small synchronous register bank to an external microprocessor bus. One static select pin chooses how two control pins are read. In the enable/direction convention, one pin enables a transfer and the other gives its direction. In the split-strobe convention, the same two pins are separate active-low read and write strobes. Chip select is active low and must be asserted for any transfer. An address-latch strobe captures the 8-bit register address, and the 16-bit data bus is driven only during a decoded read.

All bus inputs are asynchronous to the internal clock, so each one passes through a two-stage synchronizer first. A write is committed once, on the first clock where the synchronized and decoded write strobe is seen active. An optional write-hold mode blocks the write strobe while the address-latch strobe is high. This gives the address time to settle before any write can happen. The bus data pins are modelled as separate input, output and output-enable signals, which a pad ring joins into one bidirectional bus. The bus protocol is strobe-based, so the block applies no valid/ready back-pressure, and every pin is a plain level signal.

Top module: `mpu_bus_slave`

## Requirements
- R1: An active-low `rst_n` clears every register to 0 and the latched address to 0, and holds `dq_oe` low. After reset, any read returns 0.
- R2: With `conv_sel`=1, `cs_n`=0, `ctl_en_wr`=1 and `ctl_dir_rd`=0, `dq_in` is written to the register at the latched address.
- R3: With `conv_sel`=1, `cs_n`=0, `ctl_en_wr`=1 and `ctl_dir_rd`=1, `dq_oe` rises within three clocks and `dq_out` carries the register at the latched address.
- R4: With `conv_sel`=1 and `ctl_en_wr`=0, nothing is transferred, whatever the value of `ctl_dir_rd`. `dq_oe` stays low and no register changes.
- R5: With `conv_sel`=0, `cs_n`=0, `ctl_dir_rd`=0 and `ctl_en_wr`=1, a read is performed, in the same way as in R3.
- R6: With `conv_sel`=0, `cs_n`=0, `ctl_en_wr`=0 and `ctl_dir_rd`=1, a write is performed, in the same way as in R2.
- R7: With `conv_sel`=0 and both `ctl_en_wr` and `ctl_dir_rd` low, the cycle is idle. `dq_oe` stays low and no register changes.
- R8: While `cs_n` is high, no read or write takes place in either convention.
- R9: With `wr_hold_en`=1, a write strobe given while `ale` is high writes nothing. With `wr_hold_en`=0, the same strobe writes normally.
- R10: `addr_pins` is captured while `ale` is high. The captured value is held unchanged while `ale` is low.
- R11: One write strobe commits exactly once. If `dq_in` changes while the strobe is still held, the register keeps the first value.
- R12: Only addresses below DEPTH (16) exist. A write above that range is ignored and does not alias onto a lower register. A read above that range returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_sel | input | 1 | 1 = enable/direction convention, 0 = split active-low strobes |
| cs_n | input | 1 | Chip select, active low |
| ctl_en_wr | input | 1 | Transfer enable (conv 1) or write strobe, active low (conv 0) |
| ctl_dir_rd | input | 1 | Direction, 1 = read (conv 1) or read strobe, active low (conv 0) |
| ale | input | 1 | Address-latch strobe, active high |
| wr_hold_en | input | 1 | 1 = block writes while `ale` is high |
| addr_pins | input | 8 | Register address bus |
| dq_in | input | 16 | Data bus, value seen at the pins |
| dq_out | output | 16 | Data bus, value driven on reads |
| dq_oe | output | 1 | Data bus output enable |

## Verification
The bound checker checks, on every clock, the rules that hold for the synchronized control inputs:
- With chip select high, with the enable low in the enable/direction convention, or with both split strobes low, there is no output enable and no commit.
- No commit happens while the write hold is active and the address-latch strobe is high.
- A commit never lasts two cycles in a row.
- The latched address never moves while the address-latch strobe is low.

Only the bench's scenarios can show the data path itself. These scenarios cover:
- values written in one convention and read back in the other;
- a register that keeps its first value while the data pins change under a held strobe;
- out-of-range addresses that neither alias nor return stale data;
- a mid-run reset that clears the stored values.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpu_bus_decode.sv
module mpu_bus_decode
  import mpu_bus_pkg::*;
(
  input  logic    conv_sel,
  input  logic    cs_n,
  input  logic    ctl_en_wr,
  input  logic    ctl_dir_rd,
  input  logic    ale,
  input  logic    wr_hold_en,
  output bus_op_e op
);
  bus_op_e raw_op;

  always_comb begin
    raw_op = BUS_IDLE;
    if (!cs_n) begin
      if (conv_sel) begin
        if (ctl_en_wr) raw_op = ctl_dir_rd ? BUS_READ : BUS_WRITE;
      end else begin
        unique case ({ctl_en_wr, ctl_dir_rd})
          2'b10:   raw_op = BUS_READ;
          2'b01:   raw_op = BUS_WRITE;
          default: raw_op = BUS_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    op = raw_op;
    if (raw_op == BUS_WRITE && wr_hold_en && ale) op = BUS_IDLE;
  end
endmodule

// File: rtl/mpu_reg_bank.sv
module mpu_reg_bank #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic                         in_range;
  logic [IDX_W-1:0]             idx;

  assign in_range = ((addr >> IDX_W) == '0);
  assign idx      = addr[IDX_W-1:0];

  for (genvar r = 0; r < DEPTH; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (wr_en && in_range && idx == IDX_W'(r))
        regs[r] <= wr_data;
    end
  end

  assign rd_data = in_range ? regs[idx] : '0;
endmodule

// File: rtl/mpu_bus_slave.sv
module mpu_bus_slave
  import mpu_bus_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_sel,
  input  logic              cs_n,
  input  logic              ctl_en_wr,
  input  logic              ctl_dir_rd,
  input  logic              ale,
  input  logic              wr_hold_en,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int CTL_W  = 6;
  localparam int SYNC_W = CTL_W + ADDR_W + DATA_W;
  // chip select resets to its inactive (high) level
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, {(SYNC_W-2){1'b0}}};

  logic              conv_s, cs_s, en_s, dir_s, ale_s, hold_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data;
  logic              wr_q, wr_act, rd_act, wr_commit;
  bus_op_e           op;

  mpu_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({conv_sel, cs_n, ctl_en_wr, ctl_dir_rd, ale, wr_hold_en, addr_pins, dq_in}),
    .q    ({conv_s, cs_s, en_s, dir_s, ale_s, hold_s, addr_s, data_s})
  );

  mpu_bus_decode u_dec (
    .conv_sel  (conv_s),
    .cs_n      (cs_s),
    .ctl_en_wr (en_s),
    .ctl_dir_rd(dir_s),
    .ale       (ale_s),
    .wr_hold_en(hold_s),
    .op        (op)
  );

  assign rd_act = (op == BUS_READ);
  assign wr_act = (op == BUS_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      if (ale_s) addr_q <= addr_s;
    end
  end

  assign wr_commit = wr_act & ~wr_q;

  mpu_reg_bank #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_commit),
    .addr   (addr_q),
    .wr_data(data_s),
    .rd_data(rd_data)
  );

  assign dq_oe  = rd_act;
  assign dq_out = rd_act ? rd_data : '0;
endmodule

// File: rtl/mpu_bus_slave_chk.sv
module mpu_bus_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_s,
  input logic              cs_s,
  input logic              en_s,
  input logic              dir_s,
  input logic              ale_s,
  input logic              hold_s,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] addr_q,
  input logic              dq_oe
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!dq_oe && !wr_commit);
    end
  end

  // R8
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> (!dq_oe && !wr_commit));

  // R4
  enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_s && !en_s) |-> (!dq_oe && !wr_commit));

  // R7
  both_strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_s && !en_s && !dir_s) |-> (!dq_oe && !wr_commit));

  // R9
  hold_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && ale_s) |-> !wr_commit);

  // R11
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R10
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(addr_q));
endmodule

bind mpu_bus_slave mpu_bus_slave_chk #(.ADDR_W(mpu_bus_pkg::ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .conv_s   (conv_s),
  .cs_s     (cs_s),
  .en_s     (en_s),
  .dir_s    (dir_s),
  .ale_s    (ale_s),
  .hold_s   (hold_s),
  .wr_commit(wr_commit),
  .addr_q   (addr_q),
  .dq_oe    (dq_oe)
);

// File: tb/mpu_bus_slave_test.sv
`timescale 1ns/1ps
module mpu_bus_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_sel = 1'b1;
  logic        cs_n = 1'b1;
  logic        ctl_en_wr = 1'b0;
  logic        ctl_dir_rd = 1'b1;
  logic        ale = 1'b0;
  logic        wr_hold_en = 1'b0;
  logic [7:0]  addr_pins = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mpu_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .conv_sel(conv_sel), .cs_n(cs_n),
    .ctl_en_wr(ctl_en_wr), .ctl_dir_rd(ctl_dir_rd), .ale(ale),
    .wr_hold_en(wr_hold_en), .addr_pins(addr_pins), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic        conv;
    logic        is_wr;
    logic [7:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 8'h03, 16'hA5A5},
    '{1'b0, 1'b1, 8'h07, 16'h1234},
    '{1'b1, 1'b1, 8'h0F, 16'hFFFF},
    '{1'b0, 1'b1, 8'h00, 16'h8001},
    '{1'b1, 1'b0, 8'h07, 16'h1234},
    '{1'b0, 1'b0, 8'h03, 16'hA5A5},
    '{1'b0, 1'b0, 8'h0F, 16'hFFFF},
    '{1'b1, 1'b0, 8'h00, 16'h8001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1;
    if (conv_sel) begin ctl_en_wr = 1'b0; ctl_dir_rd = 1'b1; end
    else          begin ctl_en_wr = 1'b1; ctl_dir_rd = 1'b1; end
  endtask

  task automatic set_strobe(input logic wr);
    cs_n = 1'b0;
    if (conv_sel) begin ctl_en_wr = 1'b1; ctl_dir_rd = ~wr; end
    else          begin ctl_en_wr = ~wr;  ctl_dir_rd = wr;  end
  endtask

  task automatic latch(input logic [7:0] a);
    ale = 1'b1; addr_pins = a;
    wait_n(4);
    ale = 1'b0;
    wait_n(3);
  endtask

  task automatic bus_write(input logic conv, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    conv_sel = conv; go_idle(); wait_n(3);
    latch(a);
    dq_in = d; set_strobe(1'b1); wait_n(6);
    go_idle(); wait_n(4);
  endtask

  task automatic bus_read(input logic conv, input logic [7:0] a, input bit do_latch,
                          output logic [15:0] val, output logic oe);
    @(negedge clk);
    conv_sel = conv; go_idle(); wait_n(3);
    if (do_latch) latch(a);
    set_strobe(1'b0); wait_n(6);
    oe = dq_oe; val = dq_out;
    go_idle(); wait_n(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        oe;

    wait_n(4);
    check("R1 oe in reset", {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 oe after reset", {31'd0, dq_oe}, 32'd0);
    bus_read(1'b1, 8'h03, 1'b1, v, oe);
    check("R1 reg clear", {16'd0, v}, 32'd0);
    check("R3 oe on read", {31'd0, oe}, 32'd1);

    // vector table: writes in both conventions with hold mode on, cross-reads
    wr_hold_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_wr) bus_write(VECS[i].conv, VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].conv, VECS[i].addr, 1'b1, v, oe);
        check(VECS[i].conv ? "R2 R3 R6 vector" : "R2 R5 R6 vector",
              {16'd0, v}, {16'd0, VECS[i].data});
        check("R3 R5 oe vector", {31'd0, oe}, 32'd1);
      end
    end

    // R4: enable low with direction=write in conv 1
    @(negedge clk); conv_sel = 1'b1; go_idle(); wait_n(3);
    latch(8'h03); dq_in = 16'hDEAD;
    cs_n = 1'b0; ctl_en_wr = 1'b0; ctl_dir_rd = 1'b0; wait_n(6);
    check("R4 no oe", {31'd0, dq_oe}, 32'd0);
    go_idle(); wait_n(4);
    bus_read(1'b1, 8'h03, 1'b1, v, oe);
    check("R4 no write", {16'd0, v}, 32'h0000A5A5);

    // R7: both split strobes low
    @(negedge clk); conv_sel = 1'b0; go_idle(); wait_n(3);
    latch(8'h03); dq_in = 16'hBEEF;
    cs_n = 1'b0; ctl_en_wr = 1'b0; ctl_dir_rd = 1'b0; wait_n(6);
    check("R7 no oe", {31'd0, dq_oe}, 32'd0);
    go_idle(); wait_n(4);
    bus_read(1'b0, 8'h03, 1'b1, v, oe);
    check("R7 no write", {16'd0, v}, 32'h0000A5A5);

    // R8: strobes with chip select high
    @(negedge clk); conv_sel = 1'b1; go_idle(); wait_n(3);
    latch(8'h07); dq_in = 16'h1111;
    cs_n = 1'b1; ctl_en_wr = 1'b1; ctl_dir_rd = 1'b0; wait_n(6);
    ctl_dir_rd = 1'b1; wait_n(6);
    check("R8 no oe", {31'd0, dq_oe}, 32'd0);
    go_idle(); wait_n(4);
    bus_read(1'b1, 8'h07, 1'b1, v, oe);
    check("R8 no write", {16'd0, v}, 32'h00001234);

    // R9: write while ale high, hold on then off
    for (int h = 1; h >= 0; h--) begin
      @(negedge clk); wr_hold_en = h[0]; conv_sel = 1'b1; go_idle(); wait_n(3);
      ale = 1'b1; addr_pins = 8'h05; dq_in = (h == 1) ? 16'h5555 : 16'h6666;
      wait_n(3);
      set_strobe(1'b1); wait_n(6);
      go_idle(); wait_n(4);
      ale = 1'b0; wait_n(3);
      bus_read(1'b1, 8'h05, 1'b1, v, oe);
      check(h == 1 ? "R9 hold blocks" : "R9 no hold writes",
            {16'd0, v}, (h == 1) ? 32'd0 : 32'h00006666);
    end
    wr_hold_en = 1'b0;

    // R10: address held while ale low
    bus_write(1'b0, 8'h0A, 16'hAAAA);
    bus_write(1'b0, 8'h0B, 16'hBBBB);
    @(negedge clk); latch(8'h0A);
    addr_pins = 8'h0B;
    bus_read(1'b0, 8'h00, 1'b0, v, oe);
    check("R10 addr held", {16'd0, v}, 32'h0000AAAA);

    // R11: data changes under a held write strobe
    @(negedge clk); conv_sel = 1'b0; go_idle(); wait_n(3);
    latch(8'h0C); dq_in = 16'h0C0C; set_strobe(1'b1); wait_n(6);
    dq_in = 16'hC0C0; wait_n(6);
    go_idle(); wait_n(4);
    bus_read(1'b0, 8'h0C, 1'b1, v, oe);
    check("R11 single commit", {16'd0, v}, 32'h00000C0C);

    // R12: out-of-range address
    bus_write(1'b1, 8'h13, 16'h7777);
    bus_read(1'b1, 8'h03, 1'b1, v, oe);
    check("R12 no alias", {16'd0, v}, 32'h0000A5A5);
    bus_read(1'b1, 8'h13, 1'b1, v, oe);
    check("R12 out of range reads 0", {16'd0, v}, 32'd0);

    // R1: reset during operation
    @(negedge clk); rst_n = 1'b0; wait_n(3);
    check("R1 oe in mid reset", {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1; wait_n(3);
    bus_read(1'b1, 8'h07, 1'b1, v, oe);
    check("R1 cleared by reset", {16'd0, v}, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule